// File: doc/BRIEF.md
# Trap Entry Controller

This unit takes a single-cycle trap request from the core and commits the state changes for entering a trap handler. Each request carries a cause code, a flag that marks it as an interrupt or an exception, the faulting address, the current program counter and the current privilege. On the next clock edge the unit has chosen machine or supervisor handling and written that mode's cause, exception PC and trap value. It has also stacked the interrupt enables, switched the privilege and produced the handler address.

The unit holds two delegation masks, one for exceptions and one for interrupts, and a handler base for each mode. An enable register holds the supervisor and machine interrupt enables. All of these are loaded through a write-only register port. An environment-call request arrives with one generic code, and the unit recodes it from the caller's privilege before it decides where the trap goes. Interrupts can enter through a per-cause slot in a vector table.

Top module: `trap_entry_ctrl`

## Requirements
- R1: A trap goes to supervisor mode only when `priv_i` is 0 (user) or 1 (supervisor) and bit `code` is set in the mask chosen by the trap kind: the interrupt mask for interrupts, the exception mask for exceptions. Every other trap goes to machine mode. `to_smode_o` reports the choice. `priv_i` = 2 is reserved and never driven.
- R2: On supervisor entry, `s_spie_o` takes the old `s_sie_o`, `s_spp_o` takes bit 0 of `priv_i`, and `s_sie_o` clears. The machine-side enable fields keep their values.
- R3: On machine entry, `m_mpie_o` takes the old `m_mie_o`, the 2-bit `m_mpp_o` takes `priv_i`, and `m_mie_o` clears. The supervisor-side enable fields keep their values.
- R4: The target mode's cause register holds the final code in its low bits and zeros above it. Its most significant bit is set for an interrupt and clear for an exception.
- R5: The target mode's exception PC captures `pc_i`. `priv_o` becomes 1 for supervisor entry and 3 for machine entry.
- R6: `next_pc_o` is the target mode's base with bits [1:0] cleared. When the base's bits [1:0] equal 1 and the trap is an interrupt, 4 x code is added.
- R7: The target mode's trap value takes `addr_i` only for exceptions with code 0, 1, 4, 5, 6, 7, 12, 13 or 15 (misaligned, access fault, page fault). It is zero for every other exception and for every interrupt.
- R8: An exception with code 8 (environment call) is recoded before routing: to 8 from `priv_i` = 0, to 9 from `priv_i` = 1 and to 11 from `priv_i` = 3. The delegation bit of the recoded value decides the route.
- R9: All trap updates appear one edge after the cycle in which `trap_valid_i` is high. `trap_done_o` is high in exactly that following cycle. Back-to-back requests in consecutive cycles are each handled.
- R10: A register write with `cfg_we_i` high stores `cfg_wdata_i` at `cfg_addr_i`. Address 0 is the exception mask, 1 the interrupt mask, 2 the supervisor base and 3 the machine base. At address 4, bit 0 is the supervisor enable and bit 1 the machine enable. Writes to addresses 5 to 7 change nothing.
- R11: A write in the same cycle as a trap does not affect that trap: the trap uses the old masks and bases. At address 4, the enable that the trap clears ends at 0, and the other enable takes the written bit.
- R12: After reset, `priv_o` is 3, `trap_done_o` is 0, and every cause, PC, trap value, enable, base and mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trap_valid_i | input | 1 | Trap request, one cycle per trap |
| trap_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_code_i | input | CW | Cause code |
| addr_i | input | XLEN | Faulting address |
| pc_i | input | XLEN | PC of the trapping instruction |
| priv_i | input | 2 | Privilege at the trap |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | AW | Register address |
| cfg_wdata_i | input | XLEN | Register write data |
| trap_done_o | output | 1 | Trap committed in the previous edge |
| to_smode_o | output | 1 | Last trap was taken in supervisor mode |
| priv_o | output | 2 | Privilege after trap entry |
| next_pc_o | output | XLEN | Handler address |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine trap value |
| s_sie_o | output | 1 | Supervisor interrupt enable |
| s_spie_o | output | 1 | Previous supervisor enable |
| s_spp_o | output | 1 | Previous privilege for supervisor entry |
| m_mie_o | output | 1 | Machine interrupt enable |
| m_mpie_o | output | 1 | Previous machine enable |
| m_mpp_o | output | 2 | Previous privilege for machine entry |

## Verification
A register write and a trap can fall in the same cycle. The write can hit a delegation mask, a base or the enable register that the trap itself rewrites. The bench raises a trap while writing a new machine base, and again while writing the enable register. It judges the first case by the handler address of that trap and of the next one. It judges the second by the final enable bits: the trap-cleared bit stays 0, the untouched bit takes the written value, and the stacked bit holds the pre-write enable.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_R = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  localparam int unsigned ECALL_U = 8;
  localparam int unsigned ECALL_S = 9;
  localparam int unsigned ECALL_M = 11;

  localparam logic [2:0] CFG_EXC_DELEG = 3'd0;
  localparam logic [2:0] CFG_IRQ_DELEG = 3'd1;
  localparam logic [2:0] CFG_S_BASE    = 3'd2;
  localparam logic [2:0] CFG_M_BASE    = 3'd3;
  localparam logic [2:0] CFG_ENABLES   = 3'd4;

  // exception codes that carry an address into the trap value
  function automatic logic addr_cause(input int unsigned c);
    case (c)
      0, 1, 4, 5, 6, 7, 12, 13, 15: addr_cause = 1'b1;
      default:                      addr_cause = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned CW   = $clog2(XLEN)
) (
  input  logic            irq_i,
  input  logic [CW-1:0]   code_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] exc_deleg_i,
  input  logic [XLEN-1:0] irq_deleg_i,
  output logic [CW-1:0]   code_o,
  output logic            to_s_o,
  output logic            keep_addr_o
);
  logic [XLEN-1:0] mask;
  logic            low_priv;

  always_comb begin
    code_o = code_i;
    if (!irq_i && (int'(code_i) == ECALL_U)) begin
      unique case (priv_i)
        PRIV_M:  code_o = CW'(ECALL_M);
        PRIV_S:  code_o = CW'(ECALL_S);
        default: code_o = CW'(ECALL_U);
      endcase
    end
  end

  assign mask        = irq_i ? irq_deleg_i : exc_deleg_i;
  assign low_priv    = (priv_i == PRIV_U) || (priv_i == PRIV_S);
  assign to_s_o      = low_priv && mask[code_o];
  assign keep_addr_o = !irq_i && addr_cause(int'(code_o));
endmodule

// File: rtl/trap_vec.sv
module trap_vec #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CW     = $clog2(XLEN),
  parameter bit          VEC_EN = 1'b1
) (
  input  logic [XLEN-1:0] base_i,
  input  logic            irq_i,
  input  logic [CW-1:0]   code_i,
  output logic [XLEN-1:0] npc_o
);
  localparam int unsigned PADW = XLEN - CW - 2;

  logic [XLEN-1:0] aligned;
  assign aligned = {base_i[XLEN-1:2], 2'b00};

  generate
    if (VEC_EN) begin : g_vectored
      logic [XLEN-1:0] slot;
      assign slot  = {{PADW{1'b0}}, code_i, 2'b00};
      assign npc_o = (irq_i && base_i[1:0] == 2'b01) ? aligned + slot : aligned;
    end else begin : g_direct
      assign npc_o = aligned;
    end
  endgenerate
endmodule

// File: rtl/trap_cfg.sv
module trap_cfg
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] exc_deleg_o,
  output logic [XLEN-1:0] irq_deleg_o,
  output logic [XLEN-1:0] s_base_o,
  output logic [XLEN-1:0] m_base_o
);
  logic [3:0] hit;

  for (genvar i = 0; i < 4; i++) begin : g_dec
    assign hit[i] = we_i && (addr_i == AW'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_deleg_o <= '0;
      irq_deleg_o <= '0;
      s_base_o    <= '0;
      m_base_o    <= '0;
    end else begin
      if (hit[CFG_EXC_DELEG]) exc_deleg_o <= wdata_i;
      if (hit[CFG_IRQ_DELEG]) irq_deleg_o <= wdata_i;
      if (hit[CFG_S_BASE])    s_base_o    <= wdata_i;
      if (hit[CFG_M_BASE])    m_base_o    <= wdata_i;
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned AW     = 3,
  parameter bit          VEC_EN = 1'b1,
  localparam int unsigned CW    = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trap_valid_i,
  input  logic            trap_irq_i,
  input  logic [CW-1:0]   trap_code_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [1:0]      priv_i,
  input  logic            cfg_we_i,
  input  logic [AW-1:0]   cfg_addr_i,
  input  logic [XLEN-1:0] cfg_wdata_i,
  output logic            trap_done_o,
  output logic            to_smode_o,
  output logic [1:0]      priv_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] scause_o,
  output logic [XLEN-1:0] sepc_o,
  output logic [XLEN-1:0] stval_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] mtval_o,
  output logic            s_sie_o,
  output logic            s_spie_o,
  output logic            s_spp_o,
  output logic            m_mie_o,
  output logic            m_mpie_o,
  output logic [1:0]      m_mpp_o
);
  localparam int unsigned HIW = XLEN - CW - 1;

  logic [XLEN-1:0] exc_deleg, irq_deleg, s_base, m_base;
  logic [CW-1:0]   fin_code;
  logic            to_s, keep_addr;
  logic [XLEN-1:0] sel_base, npc;
  logic [XLEN-1:0] cause_val, tval_val;
  logic            en_we;

  trap_cfg #(.XLEN(XLEN), .AW(AW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .exc_deleg_o (exc_deleg),
    .irq_deleg_o (irq_deleg),
    .s_base_o    (s_base),
    .m_base_o    (m_base)
  );

  trap_route #(.XLEN(XLEN), .CW(CW)) u_route (
    .irq_i       (trap_irq_i),
    .code_i      (trap_code_i),
    .priv_i      (priv_i),
    .exc_deleg_i (exc_deleg),
    .irq_deleg_i (irq_deleg),
    .code_o      (fin_code),
    .to_s_o      (to_s),
    .keep_addr_o (keep_addr)
  );

  assign sel_base = to_s ? s_base : m_base;

  trap_vec #(.XLEN(XLEN), .CW(CW), .VEC_EN(VEC_EN)) u_vec (
    .base_i (sel_base),
    .irq_i  (trap_irq_i),
    .code_i (fin_code),
    .npc_o  (npc)
  );

  assign cause_val = {trap_irq_i, {HIW{1'b0}}, fin_code};
  assign tval_val  = keep_addr ? addr_i : '0;
  assign en_we     = cfg_we_i && (cfg_addr_i == CFG_ENABLES);

  // trap commit: records, privilege, handler address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_done_o <= 1'b0;
      to_smode_o  <= 1'b0;
      priv_o      <= PRIV_M;
      next_pc_o   <= '0;
      scause_o    <= '0;
      sepc_o      <= '0;
      stval_o     <= '0;
      mcause_o    <= '0;
      mepc_o      <= '0;
      mtval_o     <= '0;
    end else begin
      trap_done_o <= trap_valid_i;
      if (trap_valid_i) begin
        to_smode_o <= to_s;
        next_pc_o  <= npc;
        if (to_s) begin
          priv_o   <= PRIV_S;
          scause_o <= cause_val;
          sepc_o   <= pc_i;
          stval_o  <= tval_val;
        end else begin
          priv_o   <= PRIV_M;
          mcause_o <= cause_val;
          mepc_o   <= pc_i;
          mtval_o  <= tval_val;
        end
      end
    end
  end

  // enable stack; a trap overrides the write on the fields it owns
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_sie_o  <= 1'b0;
      s_spie_o <= 1'b0;
      s_spp_o  <= 1'b0;
      m_mie_o  <= 1'b0;
      m_mpie_o <= 1'b0;
      m_mpp_o  <= 2'b00;
    end else if (trap_valid_i && to_s) begin
      s_spie_o <= s_sie_o;
      s_spp_o  <= priv_i[0];
      s_sie_o  <= 1'b0;
      if (en_we) m_mie_o <= cfg_wdata_i[1];
    end else if (trap_valid_i) begin
      m_mpie_o <= m_mie_o;
      m_mpp_o  <= priv_i;
      m_mie_o  <= 1'b0;
      if (en_we) s_sie_o <= cfg_wdata_i[0];
    end else if (en_we) begin
      s_sie_o <= cfg_wdata_i[0];
      m_mie_o <= cfg_wdata_i[1];
    end
  end

  assert_mach_route_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && priv_i == PRIV_M |=> !to_smode_o && priv_o == PRIV_M);

  assert_s_stack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> !to_smode_o ||
      (!s_sie_o && s_spie_o == $past(s_sie_o) && s_spp_o == $past(priv_i[0])
       && m_mpie_o == $past(m_mpie_o) && m_mpp_o == $past(m_mpp_o)));

  assert_m_stack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> to_smode_o ||
      (!m_mie_o && m_mpie_o == $past(m_mie_o) && m_mpp_o == $past(priv_i)
       && s_spie_o == $past(s_spie_o) && s_spp_o == $past(s_spp_o)));

  assert_cause_msb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> (to_smode_o ? scause_o[XLEN-1] : mcause_o[XLEN-1]) == $past(trap_irq_i));

  assert_epc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> (to_smode_o ? sepc_o : mepc_o) == $past(pc_i));

  assert_npc_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && !trap_irq_i |=> next_pc_o[1:0] == 2'b00);

  assert_irq_tval_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && trap_irq_i |=> (to_smode_o ? stval_o : mtval_o) == '0);

  assert_ecall_m_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && !trap_irq_i && trap_code_i == CW'(ECALL_U) && priv_i == PRIV_M
    |=> mcause_o[CW-1:0] == CW'(ECALL_M));

  assert_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> trap_done_o);

  assert_no_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i |=> !trap_done_o);
endmodule

// File: tb/trap_entry_ctrl_bench.sv
module trap_entry_ctrl_bench;
  localparam int XLEN = 32;
  localparam int CW   = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trap_valid = 1'b0, trap_irq = 1'b0;
  logic [CW-1:0]   trap_code = '0;
  logic [XLEN-1:0] addr = '0, pc = '0;
  logic [1:0]      priv = 2'd3;
  logic            cfg_we = 1'b0;
  logic [2:0]      cfg_addr = '0;
  logic [XLEN-1:0] cfg_wdata = '0;
  logic            done, to_s, s_sie, s_spie, s_spp, m_mie, m_mpie;
  logic [1:0]      priv_out, m_mpp;
  logic [XLEN-1:0] npc, scause, sepc, stval, mcause, mepc, mtval;

  always #5 clk = ~clk;

  trap_entry_ctrl u_trap_entry_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(trap_valid), .trap_irq_i(trap_irq),
    .trap_code_i(trap_code), .addr_i(addr), .pc_i(pc), .priv_i(priv),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .trap_done_o(done), .to_smode_o(to_s), .priv_o(priv_out), .next_pc_o(npc),
    .scause_o(scause), .sepc_o(sepc), .stval_o(stval), .mcause_o(mcause),
    .mepc_o(mepc), .mtval_o(mtval), .s_sie_o(s_sie), .s_spie_o(s_spie),
    .s_spp_o(s_spp), .m_mie_o(m_mie), .m_mpie_o(m_mpie), .m_mpp_o(m_mpp)
  );

  typedef struct {
    logic            to_s;
    logic [1:0]      priv;
    logic [XLEN-1:0] npc, cause, epc, tval;
    logic [7:0]      stat;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0, cycles = 0;

  // bench model of the programmable state
  logic [XLEN-1:0] md_exc = '0, md_irq = '0, md_sb = '0, md_mb = '0;
  logic md_sie = 0, md_spie = 0, md_spp = 0, md_mie = 0, md_mpie = 0;
  logic [1:0] md_mpp = 0;

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic addr_code(input int c);
    return c inside {0, 1, 4, 5, 6, 7, 12, 13, 15};
  endfunction

  // drive one cycle of stimulus; model trap then write
  task automatic put(input logic v, input logic irq, input int code, input logic [XLEN-1:0] a,
                     input logic [XLEN-1:0] p, input logic [1:0] pr,
                     input logic we, input logic [2:0] wa, input logic [XLEN-1:0] wd);
    exp_t e;
    int fc;
    logic [XLEN-1:0] dm, base;
    trap_valid = v; trap_irq = irq; trap_code = CW'(code); addr = a; pc = p; priv = pr;
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    if (v) begin
      fc = code;
      if (!irq && code == 8) fc = (pr == 2'd3) ? 11 : (pr == 2'd1) ? 9 : 8;
      dm = irq ? md_irq : md_exc;
      e.to_s = (pr <= 2'd1) && dm[fc];
      e.priv = e.to_s ? 2'd1 : 2'd3;
      base = e.to_s ? md_sb : md_mb;
      e.npc = {base[XLEN-1:2], 2'b00} + ((irq && base[1:0] == 2'b01) ? XLEN'(fc * 4) : '0);
      e.cause = {irq, 26'd0, 5'(fc)};
      e.epc = p;
      e.tval = (!irq && addr_code(fc)) ? a : '0;
      if (e.to_s) begin md_spie = md_sie; md_spp = pr[0]; md_sie = 0; end
      else begin md_mpie = md_mie; md_mpp = pr; md_mie = 0; end
      if (we && wa == 3'd4) begin
        if (e.to_s) md_mie = wd[1]; else md_sie = wd[0];
      end
      e.stat = {md_sie, md_spie, md_spp, md_mie, md_mpie, md_mpp, 1'b0};
      exp_q.push_back(e);
    end else if (we && wa == 3'd4) begin
      md_sie = wd[0]; md_mie = wd[1];
    end
    if (we) begin
      case (wa)
        3'd0: md_exc = wd;
        3'd1: md_irq = wd;
        3'd2: md_sb = wd;
        3'd3: md_mb = wd;
        default: ;
      endcase
    end
  endtask

  task automatic idle();
    trap_valid = 0; cfg_we = 0;
  endtask

  task automatic trap(input logic irq, input int code, input logic [XLEN-1:0] a,
                      input logic [XLEN-1:0] p, input logic [1:0] pr);
    @(negedge clk); put(1, irq, code, a, p, pr, 0, 0, 0);
    @(negedge clk); idle();
  endtask

  task automatic wr(input logic [2:0] wa, input logic [XLEN-1:0] wd);
    @(negedge clk); put(0, 0, 0, 0, 0, 0, 1, wa, wd);
    @(negedge clk); idle();
  endtask

  // monitor: scoreboard pop on every committed trap
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk("R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R1 route", XLEN'(to_s), XLEN'(e.to_s));
        chk("R5 priv", XLEN'(priv_out), XLEN'(e.priv));
        chk("R6 next pc", npc, e.npc);
        chk("R4/R8 cause", e.to_s ? scause : mcause, e.cause);
        chk("R5 epc", e.to_s ? sepc : mepc, e.epc);
        chk("R7 tval", e.to_s ? stval : mtval, e.tval);
        chk("R2/R3/R11 enables", XLEN'({s_sie, s_spie, s_spp, m_mie, m_mpie, m_mpp, 1'b0}),
            XLEN'(e.stat));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog actual=%0d expected=<20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset values
    chk("R12 priv", XLEN'(priv_out), 3);
    chk("R12 done", XLEN'(done), 0);
    chk("R12 npc", npc, 0);
    chk("R12 mcause", mcause, 0);
    chk("R12 enables", XLEN'({s_sie, s_spie, s_spp, m_mie, m_mpie, m_mpp}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 configure
    wr(3'd0, (32'd1 << 8) | (32'd1 << 13) | (32'd1 << 2));
    wr(3'd1, (32'd1 << 5) | (32'd1 << 1));
    wr(3'd2, 32'h8000_0101);
    wr(3'd3, 32'h1000_0001);

    trap(0, 13, 32'hDEAD_BEE0, 32'h0000_1000, 2'd0); // R1 R7 delegated page fault
    trap(0, 13, 32'hDEAD_BEE4, 32'h0000_1004, 2'd3); // R1 machine keeps it
    trap(0, 8,  32'h1111_1111, 32'h0000_2000, 2'd0); // R8 user call, delegated
    trap(0, 8,  32'h2222_2222, 32'h0000_2004, 2'd1); // R8 supervisor call -> 9 machine
    trap(0, 8,  32'h3333_3333, 32'h0000_2008, 2'd3); // R8 machine call -> 11
    trap(1, 5,  32'h4444_4444, 32'h0000_3000, 2'd1); // R6 vectored supervisor irq
    trap(1, 7,  32'h5555_5555, 32'h0000_3004, 2'd0); // R6 vectored machine irq
    trap(1, 13, 32'h6666_6666, 32'h0000_3008, 2'd0); // R1 irq uses irq mask, R7 tval 0
    trap(0, 2,  32'h7777_7777, 32'h0000_300C, 2'd0); // R7 non-address exception
    trap(0, 0,  32'h8888_8881, 32'h0000_3010, 2'd1); // R7 misaligned to machine
    trap(1, 1,  32'h9999_9999, 32'h0000_3014, 2'd3); // R1 delegated irq from machine

    wr(3'd4, 32'h3);                                  // R10 enables on
    trap(0, 13, 32'hA000_0000, 32'h0000_4000, 2'd1); // R2 spie from sie
    trap(0, 5,  32'hA000_0004, 32'h0000_4004, 2'd0); // R3 mpie from mie

    // R11 collision: supervisor trap with enable write
    @(negedge clk); put(1, 0, 13, 32'hB000_0000, 32'h0000_5000, 2'd0, 1, 3'd4, 32'h3);
    @(negedge clk); idle();
    // R11 collision: machine trap with base write; old base used
    @(negedge clk); put(1, 1, 9, 32'hB000_0004, 32'h0000_5004, 2'd3, 1, 3'd3, 32'h2000_0000);
    @(negedge clk); idle();
    trap(1, 9, 32'hB000_0008, 32'h0000_5008, 2'd3);  // R6 new direct base

    // R10 writes to unused addresses are ignored
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    trap(0, 6, 32'hC000_0000, 32'h0000_6000, 2'd0);
    trap(1, 5, 32'hC000_0004, 32'h0000_6004, 2'd0);

    // R9 back-to-back requests
    @(negedge clk); put(1, 0, 4,  32'hD000_0000, 32'h0000_7000, 2'd3, 0, 0, 0);
    @(negedge clk); put(1, 0, 13, 32'hD000_0004, 32'h0000_7004, 2'd0, 0, 0, 0);
    @(negedge clk); put(1, 0, 8,  32'hD000_0008, 32'h0000_7008, 2'd1, 0, 0, 0);
    @(negedge clk); idle();

    repeat (4) @(negedge clk);
    chk("R9 all results seen", XLEN'(exp_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule